// File: doc/BRIEF.md
# Vector Display Bus Write Interface

This block is the register front end of an XY vector display output stage. A host drives an asynchronous parallel bus with 32 data bits, 16 address bits, a data strobe and a read/not-write line. The block brings the strobe into its own clock domain through a short synchroniser chain. It checks the board-select field in the top two address bits and picks one of four registers from the bottom two.

A single position write carries both axes: the X level sits in the upper half of the data word and the Y level in the lower half. That write loads both DAC holding registers on the same clock edge. It also emits a one-cycle pixel-start pulse, which tells the pulse counters to load the start and end timing values and begin drawing. The timing values have their own registers and are written before position writes. They are kept until the host changes them, so a run of pixels with the same timing needs only position writes.

A busy flag covers the time from the pixel-start pulse until the external timing logic reports completion. A position write that arrives while the block is busy is dropped and recorded in a sticky overrun flag. Reads return register contents combinationally while the strobe is held.

Top module: `vd_bus_slave`

## Requirements
- R1: While and after reset (bus_rst_n low), dac_x, dac_y, start_time, end_time, pix_start and all status bits are 0.
- R2: A write whose address bits [15:14] differ from BOARD_ID (default 2'b00) changes no register and produces no pix_start.
- R3: A write to register 0 (address bits [1:0] = 2'b00) while idle loads dac_x from data bits [31:16] and dac_y from data bits [15:0] on the same edge, and pix_start is high for exactly that one cycle.
- R4: The register update and the pix_start pulse take effect on the (SYNC_STAGES+1)th rising clock edge after the strobe is first sampled high; with SYNC_STAGES=2 that is the third edge, giving a bounded latency.
- R5: A write to register 1 (bits [1:0] = 2'b01) loads start_time from data bits [3:0] only, and produces no pix_start.
- R6: A write to register 2 (bits [1:0] = 2'b10) loads end_time from data bits [7:0] only, and produces no pix_start.
- R7: start_time and end_time keep their values across any number of pixel draws until they are rewritten.
- R8: One strobe assertion causes at most one register action, however long the strobe is held.
- R9: When bus_rnw is 1 the strobe writes nothing. While strobe, bus_rnw and board select are all true, bus_rdata returns {dac_x,dac_y} for register 0, start_time for 1, end_time for 2, and status for 3; otherwise bus_rdata is 0. Status bit 0 is busy, bit 1 follows start_active, bit 2 follows end_active, and bit 3 is overrun. Writes to register 3 are ignored.
- R10: Busy is set on the edge that issues pix_start, and is cleared on the edge where draw_done is sampled high.
- R11: A position write while busy leaves dac_x and dac_y unchanged, produces no pix_start, and sets overrun. Overrun stays set until reset.
- R12: Reset applied during a draw clears busy, overrun and the DAC registers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal 20 MHz clock |
| bus_rst_n | input | 1 | Bus reset, active low, asynchronous |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 32 | Bus write data |
| bus_strobe | input | 1 | Data strobe, active high, asynchronous |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| draw_done | input | 1 | Pixel timing finished, from the pulse counters |
| start_active | input | 1 | Start-timer status from the pulse counters |
| end_active | input | 1 | End-timer status from the pulse counters |
| pix_start | output | 1 | One-cycle pulse that loads the counters and starts a draw |
| dac_x | output | 16 | X DAC holding register |
| dac_y | output | 16 | Y DAC holding register |
| start_time | output | 4 | Brightening start value |
| end_time | output | 8 | Brightening end value |

## Verification
The bench uses the default parameters: SYNC_STAGES=2, BOARD_ID=2'b00 and 4-bit and 8-bit timing fields. Under these values the three-edge latency can be counted exactly for every pixel. A foreign board select of 2'b01 and data words with upper bits set are enough to show that masking and truncation work. A scoreboard pairs each queued position write with its pix_start pulse and the cycle count from strobe to pulse. Any pulse that the queue does not expect shows up at once, and this covers the overrun, read, foreign-board and long-strobe cases.

// File: rtl/vd_pkg.sv
package vd_pkg;
  typedef enum logic [1:0] {
    REG_POS   = 2'b00,
    REG_START = 2'b01,
    REG_END   = 2'b10,
    REG_STAT  = 2'b11
  } reg_sel_e;

  localparam int STAT_BITS = 4;

  function automatic logic [15:0] upper_axis(input logic [31:0] word);
    return word[31:16];
  endfunction

  function automatic logic [15:0] lower_axis(input logic [31:0] word);
    return word[15:0];
  endfunction

  function automatic logic [STAT_BITS-1:0] pack_status(
    input logic busy, input logic st_act, input logic en_act, input logic ovr);
    return {ovr, en_act, st_act, busy};
  endfunction
endpackage

// File: rtl/vd_strobe_sync.sv
module vd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= strobe_async;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign strobe_rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/vd_addr_decode.sv
module vd_addr_decode
  import vd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [1:0] BOARD_ID = 2'b00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              board_hit,
  output reg_sel_e          reg_sel
);
  logic unused_mid_bits;
  assign unused_mid_bits = ^addr[ADDR_W-3:2];
  assign board_hit = (addr[ADDR_W-1:ADDR_W-2] == BOARD_ID);
  assign reg_sel   = reg_sel_e'(addr[1:0]);
endmodule

// File: rtl/vd_reg_bank.sv
module vd_reg_bank
  import vd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int START_W = 4,
  parameter int END_W   = 8,
  localparam int AXIS_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pos_we,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [AXIS_W-1:0] x_q,
  output logic [AXIS_W-1:0] y_q,
  output logic [START_W-1:0] start_q,
  output logic [END_W-1:0]  end_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (pos_we) begin
        x_q <= upper_axis(wdata);
        y_q <= lower_axis(wdata);
      end
      if (start_we) start_q <= wdata[START_W-1:0];
      if (end_we)   end_q   <= wdata[END_W-1:0];
    end
  end
endmodule

// File: rtl/vd_bus_slave.sv
module vd_bus_slave
  import vd_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 32,
  parameter int         START_W     = 4,
  parameter int         END_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] BOARD_ID    = 2'b00,
  localparam int        AXIS_W      = DATA_W / 2
) (
  input  logic               clk,
  input  logic               bus_rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_strobe,
  input  logic               bus_rnw,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               draw_done,
  input  logic               start_active,
  input  logic               end_active,
  output logic               pix_start,
  output logic [AXIS_W-1:0]  dac_x,
  output logic [AXIS_W-1:0]  dac_y,
  output logic [START_W-1:0] start_time,
  output logic [END_W-1:0]   end_time
);
  logic     wr_event;
  logic     board_hit;
  reg_sel_e reg_sel;
  logic     wr_hit;
  logic     pos_req, pos_we, start_we, end_we;
  logic     busy_q, overrun_q, pix_q;
  logic [STAT_BITS-1:0] status;

  vd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(bus_rst_n), .strobe_async(bus_strobe), .strobe_rise(wr_event)
  );

  vd_addr_decode #(.ADDR_W(ADDR_W), .BOARD_ID(BOARD_ID)) u_dec (
    .addr(bus_addr), .board_hit(board_hit), .reg_sel(reg_sel)
  );

  assign wr_hit   = wr_event & board_hit & ~bus_rnw;
  assign pos_req  = wr_hit & (reg_sel == REG_POS);
  assign pos_we   = pos_req & ~busy_q;
  assign start_we = wr_hit & (reg_sel == REG_START);
  assign end_we   = wr_hit & (reg_sel == REG_END);

  vd_reg_bank #(.DATA_W(DATA_W), .START_W(START_W), .END_W(END_W)) u_regs (
    .clk(clk), .rst_n(bus_rst_n), .pos_we(pos_we), .start_we(start_we),
    .end_we(end_we), .wdata(bus_wdata), .x_q(dac_x), .y_q(dac_y),
    .start_q(start_time), .end_q(end_time)
  );

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      busy_q    <= 1'b0;
      overrun_q <= 1'b0;
      pix_q     <= 1'b0;
    end else begin
      pix_q <= pos_we;
      if (pos_we) busy_q <= 1'b1;
      else if (draw_done) busy_q <= 1'b0;
      if (pos_req && busy_q) overrun_q <= 1'b1;
    end
  end

  assign pix_start = pix_q;
  assign status    = pack_status(busy_q, start_active, end_active, overrun_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_strobe && bus_rnw && board_hit) begin
      unique case (reg_sel)
        REG_POS:   bus_rdata = {dac_x, dac_y};
        REG_START: bus_rdata[START_W-1:0] = start_time;
        REG_END:   bus_rdata[END_W-1:0] = end_time;
        REG_STAT:  bus_rdata[STAT_BITS-1:0] = status;
      endcase
    end
  end
endmodule

// File: rtl/vd_bus_slave_chk.sv
module vd_bus_slave_chk #(
  parameter int AXIS_W  = 16,
  parameter int START_W = 4
) (
  input logic               clk,
  input logic               bus_rst_n,
  input logic               wr_event,
  input logic               board_hit,
  input logic               pix_start,
  input logic               busy_q,
  input logic               overrun_q,
  input logic [AXIS_W-1:0]  dac_x,
  input logic [AXIS_W-1:0]  dac_y,
  input logic [START_W-1:0] start_time
);
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!bus_rst_n)
    pix_start |=> !pix_start);
  a_r10_busy_with_start: assert property (@(posedge clk) disable iff (!bus_rst_n)
    pix_start |-> busy_q);
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!bus_rst_n)
    overrun_q |=> overrun_q);
  a_r3_dac_moves_with_start: assert property (@(posedge clk) disable iff (!bus_rst_n)
    ((dac_x != $past(dac_x)) || (dac_y != $past(dac_y))) |-> pix_start);
  a_r8_event_single: assert property (@(posedge clk) disable iff (!bus_rst_n)
    wr_event |=> !wr_event);
  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (wr_event && !board_hit) |=> (!pix_start && $stable(start_time)));
endmodule

bind vd_bus_slave vd_bus_slave_chk #(.AXIS_W(AXIS_W), .START_W(START_W)) u_chk (
  .clk(clk), .bus_rst_n(bus_rst_n), .wr_event(wr_event), .board_hit(board_hit),
  .pix_start(pix_start), .busy_q(busy_q), .overrun_q(overrun_q),
  .dac_x(dac_x), .dac_y(dac_y), .start_time(start_time)
);

// File: tb/vd_bus_slave_tb.sv
module vd_bus_slave_tb;
  localparam int LAT = 3;

  typedef struct {
    logic [15:0] x;
    logic [15:0] y;
    int          cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_strobe = 1'b0;
  logic        bus_rnw = 1'b1;
  logic [31:0] bus_rdata;
  logic        draw_done = 1'b0;
  logic        start_active = 1'b0;
  logic        end_active = 1'b0;
  logic        pix_start;
  logic [15:0] dac_x, dac_y;
  logic [3:0]  start_time;
  logic [7:0]  end_time;

  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vd_bus_slave u_dut (
    .clk(clk), .bus_rst_n(bus_rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strobe(bus_strobe), .bus_rnw(bus_rnw), .bus_rdata(bus_rdata),
    .draw_done(draw_done), .start_active(start_active), .end_active(end_active),
    .pix_start(pix_start), .dac_x(dac_x), .dac_y(dac_y),
    .start_time(start_time), .end_time(end_time)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one strobe cycle; position writes push the expected result.
  task automatic bus_write(input logic [15:0] a, input logic [31:0] d,
                           input bit expect_pix, input int hold);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rnw = 1'b0; bus_strobe = 1'b1;
    if (expect_pix) q.push_back('{x: d[31:16], y: d[15:0], cyc: cyc});
    repeat (hold) @(negedge clk);
    bus_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rnw = 1'b1; bus_strobe = 1'b1;
    #2 d = bus_rdata;
    repeat (4) @(negedge clk);
    bus_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: every pixel-start pulse must match the oldest queued write.
  always @(negedge clk) begin
    if (bus_rst_n && pix_start) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11/R2/R8/R9 unexpected pix_start", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(dac_x == e.x, "R3 dac_x", {16'd0, dac_x}, {16'd0, e.x});
        chk(dac_y == e.y, "R3 dac_y", {16'd0, dac_y}, {16'd0, e.y});
        chk(cyc - e.cyc == LAT, "R4 latency", cyc - e.cyc, LAT);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1
    chk(dac_x == 0 && dac_y == 0, "R1 dac reset", {dac_x, dac_y}, 0);
    chk(start_time == 0 && end_time == 0 && pix_start == 0, "R1 timing reset",
        {start_time, end_time, 3'b0, pix_start}, 0);
    bus_rst_n = 1'b1;
    bus_read(16'h0003, rd);
    chk(rd == 0, "R1 status reset", rd, 0);

    // R5, R6 with masking of upper data bits
    bus_write(16'h0001, 32'hFFFF_FFF5, 0, 4);
    chk(start_time == 4'h5, "R5 start value", start_time, 5);
    bus_write(16'h0002, 32'h1234_56C8, 0, 4);
    chk(end_time == 8'hC8, "R6 end value", end_time, 8'hC8);
    bus_read(16'h0001, rd);
    chk(rd == 32'h5, "R9 read start", rd, 5);

    // R3, R4, R10
    bus_write(16'h0000, 32'h1234_ABCD, 1, 4);
    bus_read(16'h0003, rd);
    chk(rd == 32'h1, "R10 busy set", rd, 1);

    // R11: ignored while busy
    bus_write(16'h0000, 32'h5555_6666, 0, 4);
    chk(dac_x == 16'h1234 && dac_y == 16'hABCD, "R11 dac held", {dac_x, dac_y},
        32'h1234_ABCD);
    bus_read(16'h0003, rd);
    chk(rd == 32'h9, "R11 overrun set", rd, 9);

    // R10 clear by draw_done, R9 timer status inputs
    @(negedge clk); draw_done = 1'b1;
    @(negedge clk); draw_done = 1'b0;
    start_active = 1'b1; end_active = 1'b1;
    bus_read(16'h0003, rd);
    chk(rd == 32'hE, "R10 busy cleared, R11 sticky, R9 status", rd, 32'hE);
    start_active = 1'b0; end_active = 1'b0;

    // R2 foreign board
    bus_write(16'h4000, 32'h0F0F_0F0F, 0, 4);
    bus_write(16'h4001, 32'h0000_0009, 0, 4);
    chk(dac_x == 16'h1234 && start_time == 4'h5, "R2 foreign ignored",
        {dac_x, 12'd0, start_time}, {16'h1234, 16'h0005});

    // R9 write to status ignored, read strobe writes nothing
    bus_write(16'h0003, 32'hFFFF_FFFF, 0, 4);
    bus_read(16'h0003, rd);
    chk(rd == 32'h8, "R9 status write ignored", rd, 8);
    bus_wdata = 32'hDEAD_BEEF;
    bus_read(16'h0000, rd);
    chk(rd == 32'h1234_ABCD, "R9 read position", rd, 32'h1234_ABCD);

    // R8 long strobe, R7 timing persists
    bus_write(16'h0000, 32'h8000_7FFF, 1, 20);
    chk(start_time == 4'h5 && end_time == 8'hC8, "R7 timing kept",
        {start_time, end_time}, {4'h5, 8'hC8});
    @(negedge clk); draw_done = 1'b1;
    @(negedge clk); draw_done = 1'b0;
    bus_write(16'h0000, 32'h0001_0002, 1, 4);
    chk(start_time == 4'h5 && end_time == 8'hC8, "R7 timing kept twice",
        {start_time, end_time}, {4'h5, 8'hC8});

    // R12 reset during draw
    @(negedge clk); bus_rst_n = 1'b0;
    #2;
    chk(dac_x == 0 && dac_y == 0, "R12 dac cleared", {dac_x, dac_y}, 0);
    @(negedge clk); bus_rst_n = 1'b1;
    bus_read(16'h0003, rd);
    chk(rd == 0, "R12 status cleared", rd, 0);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 all pixels started", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule